// File: doc/BRIEF.md
# One-Time-Programmable Security Register Controller

This block models the command side of a flash part's security register. A 128-bit register is split into two 64-bit halves. The factory half is fixed by a parameter. The user half starts blank (all ones) and can be written once. A separate lock word decides which half still accepts programming. A host drives single-cycle write and read strobes with a word address and a 16-bit data bus.

Write cycles are decoded as commands:

- 90h switches reads to the identification map.
- FFh switches reads back to the array.
- 50h clears the sticky error flags.
- C0h arms a two-cycle program. The write that follows it carries the target address and data.

Programming can only clear bits, because the new data is ANDed into the stored word. Out-of-map programs and programs to protected words are refused, and the refusal is reported through status bits. Array reads return a fixed fill value. Reset models a fresh part: the factory half is already locked and the user half and its lock bit are blank.

Top module: `otp_secreg_ctrl`

## Requirements
- R1: After reset the read mode is array mode, a read returns the ARRAY_FILL value (default FFFFh), and both error flags are clear.
- R2: A write of command 90h selects identification reads. A write of FFh selects array reads. Only wdata[7:0] is decoded as the command.
- R3: In identification mode, word address 80h returns the lock word. In the lock word, bit 0 is the factory lock, bit 1 is the user lock (0 = locked), and all other bits are 1. Addresses 81h–84h return factory words 0–3, taken from FACTORY_ID, least significant word first. Addresses 85h–88h return user words 0–3. Any other address returns 0000h.
- R4: A write of C0h followed by any write programs the second write's address with stored AND data. The read mode becomes status mode from the C0h write onward. The status word has bit 7 = ready (always 1), bit 4 = program error, bit 1 = lock error, and all other bits 0.
- R5: A program to an address outside 80h–88h sets the program error flag only and changes no stored word.
- R6: A program to any factory word sets both error flags and leaves the word unchanged.
- R7: Programming FFFDh to 80h clears the user lock. Afterwards, programs to user words set both error flags and leave them unchanged. The lock persists through every command.
- R8: No command returns a lock bit from 0 to 1.
- R9: Error flags stay set until a 50h command clears both. 50h leaves the read mode unchanged.
- R10: A first-cycle command other than FFh, 90h, C0h or 50h changes neither the read mode nor the flags.
- R11: While rd_en is low, rdata is 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset, restores blank part |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| rd_en | input | 1 | Read strobe, enables rdata |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data or command code |
| rdata | output | 16 | Read data for the current mode and address, combinational |

## Verification
The whole identification map is read before any programming, to pin down word order and the blank lock word. Legal user programs are issued twice with overlapping patterns (F0F0h then FF0Fh). This tells an AND merge apart from a plain overwrite. Out-of-map, factory and locked-user programs are each followed by a status read, which separates the program-only error from the combined error. Each is also followed by a read-back of the target word. Unknown codes, clears issued in different modes, and a status read taken mid-setup show whether mode and flag state survive the commands that must not touch them.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int WORD_W    = 16;
  localparam int SEG_WORDS = 4;
  localparam int LOCK_ADDR = 'h80;
  localparam int FACT_BASE = LOCK_ADDR + 1;
  localparam int USER_BASE = FACT_BASE + SEG_WORDS;
  localparam int MAP_LAST  = USER_BASE + SEG_WORDS - 1;

  localparam logic [7:0] OP_READ_ARRAY = 8'hFF;
  localparam logic [7:0] OP_READ_ID    = 8'h90;
  localparam logic [7:0] OP_PGM_SETUP  = 8'hC0;
  localparam logic [7:0] OP_CLR_STAT   = 8'h50;

  typedef enum logic [1:0] {MODE_ARRAY, MODE_IDENT, MODE_STATUS} rmode_e;
  typedef enum logic [1:0] {REG_NONE, REG_LOCK, REG_FACT, REG_USER} region_e;

  // Which part of the security map a word address falls into.
  function automatic region_e region_of(input int unsigned a);
    if (a == LOCK_ADDR)                        return REG_LOCK;
    else if (a >= FACT_BASE && a < USER_BASE)  return REG_FACT;
    else if (a >= USER_BASE && a <= MAP_LAST)  return REG_USER;
    else                                       return REG_NONE;
  endfunction

  // Status: bit7 ready, bit4 program error, bit1 lock error.
  function automatic logic [WORD_W-1:0] status_word(input logic e_pgm, input logic e_lock);
    return {8'h00, 1'b1, 2'b00, e_pgm, 2'b00, e_lock, 1'b0};
  endfunction

  function automatic logic [WORD_W-1:0] lock_word(input logic f_lock, input logic u_lock);
    return {{(WORD_W-2){1'b1}}, u_lock, f_lock};
  endfunction

  // One-way programming: a bit can only be cleared.
  function automatic logic [WORD_W-1:0] otp_merge(input logic [WORD_W-1:0] old_w,
                                                   input logic [WORD_W-1:0] new_w);
    return old_w & new_w;
  endfunction
endpackage

// File: rtl/otp_cmd_fsm.sv
module otp_cmd_fsm
  import otp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] cmd,
  output rmode_e     mode,
  output logic       pgm_fire,
  output logic       clr_fire,
  output logic       cmd_ignored
);
  logic   armed;
  logic   first_cyc;
  logic   known;

  always_comb begin
    first_cyc   = wr_en && !armed;
    pgm_fire    = wr_en && armed;
    known       = (cmd == OP_READ_ARRAY) || (cmd == OP_READ_ID) ||
                  (cmd == OP_PGM_SETUP)  || (cmd == OP_CLR_STAT);
    clr_fire    = first_cyc && (cmd == OP_CLR_STAT);
    cmd_ignored = first_cyc && !known;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode  <= MODE_ARRAY;
      armed <= 1'b0;
    end else if (pgm_fire) begin
      armed <= 1'b0;
      mode  <= MODE_STATUS;
    end else if (first_cyc) begin
      case (cmd)
        OP_READ_ARRAY: mode <= MODE_ARRAY;
        OP_READ_ID:    mode <= MODE_IDENT;
        OP_PGM_SETUP: begin
          armed <= 1'b1;
          mode  <= MODE_STATUS;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/otp_store.sv
module otp_store
  import otp_pkg::*;
#(
  parameter int ADDR_W = 8
)(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        pgm_fire,
  input  logic                        clr_fire,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [WORD_W-1:0]           wdata,
  output region_e                     region,
  output logic                        f_lock,
  output logic                        u_lock,
  output logic [SEG_WORDS*WORD_W-1:0] user_flat,
  output logic                        err_pgm,
  output logic                        err_lock,
  output logic                        ev_oor,
  output logic                        ev_locked,
  output logic                        ev_user_wr
);
  logic ev_lock_wr;

  always_comb begin
    region     = region_of(32'(addr));
    ev_oor     = pgm_fire && (region == REG_NONE);
    ev_locked  = pgm_fire && ((region == REG_FACT) || ((region == REG_USER) && !u_lock));
    ev_user_wr = pgm_fire && (region == REG_USER) && u_lock;
    ev_lock_wr = pgm_fire && (region == REG_LOCK);
  end

  // Lock bits: factory lock starts cleared, user lock starts blank.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f_lock <= 1'b0;
      u_lock <= 1'b1;
    end else if (ev_lock_wr) begin
      f_lock <= f_lock & wdata[0];
      u_lock <= u_lock & wdata[1];
    end
  end

  for (genvar g = 0; g < SEG_WORDS; g++) begin : g_user
    logic hit;
    assign hit = ev_user_wr && (32'(addr) == 32'(USER_BASE + g));
    always_ff @(posedge clk) begin
      if (!rst_n)
        user_flat[g*WORD_W +: WORD_W] <= '1;
      else if (hit)
        user_flat[g*WORD_W +: WORD_W] <= otp_merge(user_flat[g*WORD_W +: WORD_W], wdata);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_pgm  <= 1'b0;
      err_lock <= 1'b0;
    end else if (clr_fire) begin
      err_pgm  <= 1'b0;
      err_lock <= 1'b0;
    end else begin
      err_pgm  <= err_pgm  | ev_oor | ev_locked;
      err_lock <= err_lock | ev_locked;
    end
  end
endmodule

// File: rtl/otp_secreg_ctrl.sv
module otp_secreg_ctrl
  import otp_pkg::*;
#(
  parameter int              ADDR_W     = 8,
  parameter logic [63:0]     FACTORY_ID = 64'h0123_4567_89AB_CDEF,
  parameter logic [15:0]     ARRAY_FILL = 16'hFFFF
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata
);
  localparam int IDX_W = $clog2(SEG_WORDS);

  rmode_e                      mode;
  region_e                     region;
  logic                        ev_pgm, ev_clr, ev_ignored;
  logic                        ev_oor, ev_locked, ev_user_wr;
  logic                        f_lock, u_lock, err_pgm, err_lock;
  logic [SEG_WORDS*WORD_W-1:0] user_flat;
  logic [IDX_W-1:0]            fidx, uidx;

  otp_cmd_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cmd(wdata[7:0]),
    .mode(mode), .pgm_fire(ev_pgm), .clr_fire(ev_clr), .cmd_ignored(ev_ignored)
  );

  otp_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .pgm_fire(ev_pgm), .clr_fire(ev_clr),
    .addr(addr), .wdata(wdata), .region(region),
    .f_lock(f_lock), .u_lock(u_lock), .user_flat(user_flat),
    .err_pgm(err_pgm), .err_lock(err_lock),
    .ev_oor(ev_oor), .ev_locked(ev_locked), .ev_user_wr(ev_user_wr)
  );

  assign fidx = IDX_W'(32'(addr) - 32'(FACT_BASE));
  assign uidx = IDX_W'(32'(addr) - 32'(USER_BASE));

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (mode)
        MODE_ARRAY:  rdata = ARRAY_FILL;
        MODE_STATUS: rdata = status_word(err_pgm, err_lock);
        default: begin
          case (region)
            REG_LOCK: rdata = lock_word(f_lock, u_lock);
            REG_FACT: rdata = FACTORY_ID[fidx*WORD_W +: WORD_W];
            REG_USER: rdata = user_flat[uidx*WORD_W +: WORD_W];
            default:  rdata = '0;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/otp_secreg_chk.sv
module otp_secreg_chk
  import otp_pkg::*;
(
  input logic                        clk,
  input logic                        rst_n,
  input logic                        rd_en,
  input logic [15:0]                 rdata,
  input rmode_e                      mode,
  input logic                        ev_oor,
  input logic                        ev_locked,
  input logic                        ev_user_wr,
  input logic                        ev_clr,
  input logic                        ev_ignored,
  input logic                        f_lock,
  input logic                        u_lock,
  input logic                        err_pgm,
  input logic                        err_lock,
  input logic [SEG_WORDS*WORD_W-1:0] user_flat
);
  assert_oor_pgm_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_oor |=> err_pgm && (err_lock == $past(err_lock)));

  assert_locked_both_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_locked |=> err_pgm && err_lock);

  assert_user_change_needs_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(user_flat) |-> $past(ev_user_wr));

  assert_lock_never_rises_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(u_lock) && !$rose(f_lock));

  assert_flags_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(err_pgm) || $fell(err_lock)) |-> $past(ev_clr));

  assert_ignored_keeps_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ignored |=> $stable(mode));

  assert_status_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && mode == MODE_STATUS) |-> rdata[7]);

  assert_idle_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == 16'h0000);
endmodule

bind otp_secreg_ctrl otp_secreg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rdata(rdata), .mode(mode),
  .ev_oor(ev_oor), .ev_locked(ev_locked), .ev_user_wr(ev_user_wr),
  .ev_clr(ev_clr), .ev_ignored(ev_ignored), .f_lock(f_lock), .u_lock(u_lock),
  .err_pgm(err_pgm), .err_lock(err_lock), .user_flat(user_flat)
);

// File: tb/otp_secreg_ctrl_tb.sv
module otp_secreg_ctrl_tb;
  localparam int          CLK_PERIOD = 10;
  localparam logic [63:0] FID  = 64'hFEDC_1357_2468_A5C3;
  localparam logic [15:0] FILL = 16'hFFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;

  int vectors = 0, fails = 0;

  // Reference model state
  int          m_mode = 0;  // 0 array, 1 ident, 2 status
  bit          m_pend = 0, m_e4 = 0, m_e1 = 0, m_ul = 1;
  logic [15:0] m_user [4] = '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF};

  otp_secreg_ctrl #(.ADDR_W(8), .FACTORY_ID(FID), .ARRAY_FILL(FILL)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] model_read(bit rd, int a);
    if (!rd) return 16'h0000;
    if (m_mode == 0) return FILL;
    if (m_mode == 2) return 16'h0080 | (16'(m_e4) << 4) | (16'(m_e1) << 1);
    if (a == 128) return 16'hFFFC | (16'(m_ul) << 1);
    if (a >= 129 && a <= 132) return FID[(a-129)*16 +: 16];
    if (a >= 133 && a <= 136) return m_user[a-133];
    return 16'h0000;
  endfunction

  task automatic model_write(int a, logic [15:0] d);
    if (m_pend) begin
      m_pend = 0;
      m_mode = 2;
      if (a == 128) m_ul = m_ul & d[1];
      else if (a >= 129 && a <= 132) begin m_e4 = 1; m_e1 = 1; end
      else if (a >= 133 && a <= 136) begin
        if (!m_ul) begin m_e4 = 1; m_e1 = 1; end
        else m_user[a-133] = m_user[a-133] & d;
      end else m_e4 = 1;
    end else begin
      case (d[7:0])
        8'hFF: m_mode = 0;
        8'h90: m_mode = 1;
        8'hC0: begin m_pend = 1; m_mode = 2; end
        8'h50: begin m_e4 = 0; m_e1 = 0; end
        default: ;
      endcase
    end
  endtask

  // Called at a falling edge: drive, compare, clock, update model.
  task automatic step(bit wr, bit rd, int a, logic [15:0] d, string tag);
    logic [15:0] exp_v;
    wr_en = wr; rd_en = rd; addr = 8'(a); wdata = d;
    #1;
    exp_v = model_read(rd, a);
    vectors++;
    if (rdata !== exp_v) begin
      fails++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rdata, exp_v);
    end
    @(posedge clk);
    if (wr && rst_n) model_write(a, d);
    @(negedge clk);
    wr_en = 0; rd_en = 0;
  endtask

  task automatic wr(int a, logic [15:0] d, string tag); step(1, 1, a, d, tag); endtask
  task automatic rd(int a, string tag);                 step(0, 1, a, 16'h0, tag); endtask

  initial begin
    #(CLK_PERIOD*5000);
    fails++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    rd(16, "R1");                         // read during reset
    @(negedge clk);
    rst_n = 1;
    rd(16, "R1");  rd(133, "R1");
    step(0, 0, 133, 16'h0, "R11");
    wr(0, 16'h0090, "R2");
    for (int a = 127; a <= 137; a++) rd(a, "R3");
    wr(0, 16'h0033, "R10"); rd(129, "R10");
    wr(0, 16'h00FF, "R2");  rd(129, "R2");
    wr(0, 16'h5512, "R10"); rd(129, "R10");
    // legal user programs with AND merge
    wr(0, 16'h00C0, "R4"); rd(0, "R4");
    wr(133, 16'hF0F0, "R4"); rd(133, "R4");
    wr(0, 16'h0090, "R4"); rd(133, "R4");
    wr(0, 16'h00C0, "R4"); wr(133, 16'hFF0F, "R4");
    wr(0, 16'h0090, "R4"); rd(133, "R4");
    // out of range
    wr(0, 16'h00C0, "R5"); wr(64, 16'h0000, "R5"); rd(0, "R5");
    wr(0, 16'h0090, "R5");
    for (int a = 133; a <= 136; a++) rd(a, "R5");
    // stickiness across setup and a good program, then clear
    wr(0, 16'h00C0, "R9"); rd(0, "R9");
    wr(134, 16'hAAAA, "R9"); rd(0, "R9");
    wr(0, 16'h0050, "R9"); rd(0, "R9");
    // factory write
    wr(0, 16'h00C0, "R6"); wr(130, 16'h0000, "R6"); rd(0, "R6");
    wr(0, 16'h0090, "R6"); rd(130, "R6");
    wr(0, 16'h0050, "R9"); rd(130, "R9");
    // user lock
    wr(0, 16'h00C0, "R7"); wr(128, 16'hFFFD, "R7");
    wr(0, 16'h0090, "R7"); rd(128, "R7");
    wr(0, 16'h00C0, "R7"); wr(134, 16'h0000, "R7"); rd(0, "R7");
    wr(0, 16'h0090, "R7"); rd(134, "R7");
    wr(0, 16'h00FF, "R7"); wr(0, 16'h0050, "R7"); wr(0, 16'h0090, "R7");
    rd(134, "R7"); rd(128, "R7");
    wr(0, 16'h00C0, "R8"); wr(128, 16'hFFFF, "R8");
    wr(0, 16'h0090, "R8"); rd(128, "R8");
    step(0, 0, 128, 16'h0, "R11");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule